// File: doc/BRIEF.md
# SPI Bit Clock Generator

This block produces the serial clock of an SPI master together with two single-cycle strobes per bit. The launch strobe tells the shift logic when to put the next bit on the wire. The sample strobe tells it when to capture the incoming bit. Each transfer is a run of write bits followed by a run of read bits. The two runs are timed by two independently programmed dividers, so a slow device can be read more slowly than it is written. The generator also reports which of the two runs is under way and flags the last system clock of the transfer.

A controller sets the divider fields, the clock polarity and phase, and the two bit counts. It then pulses `start`. All of these settings are captured at that moment, so the inputs may change while the transfer runs. A start that arrives in the final clock of a transfer opens the next transfer with no idle gap on the serial clock. A start with both counts zero completes at once and toggles nothing.

Top module: `spi_clkgen`

## Requirements
- R1: A divider field value F gives a bit period of F+2 system clocks. Every bit lasts exactly its period, and `busy` is 1 for every cycle of the transfer.
- R2: Each bit period is split into a setup half of ceil(P/2) clocks followed by a hold half of floor(P/2) clocks. An odd period therefore gives the setup half the extra clock.
- R3: The first `wr_bits` bits use the write divider and report `phase_rd`=0. The remaining `rd_bits` bits use the read divider and report `phase_rd`=1.
- R4: While no transfer runs, `sclk` equals `clk_pol`, and it follows that input as it changes.
- R5: During a setup half, `sclk` equals `clk_pol` XOR `clk_pha`. During a hold half it is the inverse. So mode (0,0) samples on rising edges, (0,1) on falling, (1,0) on falling and (1,1) on rising.
- R6: `launch` is 1 in the first clock of each bit's setup half. `sample` is 1 in the first clock of its hold half. The two are never 1 together.
- R7: `done` is 1 during the final system clock of the last bit. `busy` is 0 in the next cycle unless a new transfer is accepted.
- R8: A start with both bit counts zero raises `done` for one cycle, in the cycle after the start. `busy`, `launch` and `sample` stay 0 throughout.
- R9: A start in the cycle where `done` is 1 begins the next transfer's first setup half in the very next cycle.
- R10: A start while a transfer runs, other than in its final clock, has no effect on any output.
- R11: During and right after reset, `busy`, `launch`, `sample`, `done` and `phase_rd` are 0, and `sclk` equals `clk_pol`.
- R12: The dividers, bit counts, polarity and phase are captured at an accepted start. Later changes to those inputs do not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdiv_m2 | input | DIV_W | Write-bit divide ratio minus two |
| rdiv_m2 | input | DIV_W | Read-bit divide ratio minus two |
| clk_pol | input | 1 | Idle level of the serial clock |
| clk_pha | input | 1 | 0: sample on the first edge of a bit, 1: on the second |
| wr_bits | input | LEN_W | Number of write bits in the transfer |
| rd_bits | input | LEN_W | Number of read bits in the transfer |
| start | input | 1 | Request a transfer (single-cycle pulse) |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | Strobe: drive the next bit now |
| sample | output | 1 | Strobe: capture the incoming bit now |
| phase_rd | output | 1 | 1 while read bits are clocked |
| done | output | 1 | Final cycle of a transfer, or the completion of an empty one |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench aims at odd divide ratios. A design that put the spare clock in the hold half would move every `sample` strobe one cycle early. It also aims at the boundary between write and read bits. Choosing the divider from the wrong count there would stretch or shrink the first read bit. Chained starts in the `done` cycle are covered: a generator that returned to idle first would insert one cycle at the idle level. Starts and setting changes during a transfer are covered: a generator that accepted them, or read its settings live, would break the bit timing that the bench predicts. Empty transfers are exercised as well: a design that let them through would either hang or emit a stray launch.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;

  // Which half of a bit period the generator is in.
  typedef enum logic {
    HALF_SETUP = 1'b0,
    HALF_HOLD  = 1'b1
  } half_e;

endpackage

// File: rtl/spi_clkgen_rstsync.sv
module spi_clkgen_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/spi_clkgen_halfcnt.sv
module spi_clkgen_halfcnt
  import spi_clkgen_pkg::*;
#(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          in_hold,
  output logic          first_setup,
  output logic          first_hold,
  output logic          bit_end
);

  logic [PW-1:0] period_q, period_d;
  logic [PW-1:0] cnt_q, cnt_d;
  half_e         half_q, half_d;

  logic [PW:0]   ld_sum;
  logic [PW-1:0] ld_setup_len;
  logic [PW:0]   cur_sum;
  logic [PW-1:0] cur_setup_len;
  logic [PW-1:0] cur_hold_len;

  // Odd periods round the setup half up and the hold half down.
  always_comb begin
    ld_sum        = {1'b0, period} + {{PW{1'b0}}, 1'b1};
    ld_setup_len  = ld_sum[PW:1];
    cur_sum       = {1'b0, period_q} + {{PW{1'b0}}, 1'b1};
    cur_setup_len = cur_sum[PW:1];
    cur_hold_len  = {1'b0, period_q[PW-1:1]};
  end

  always_comb begin
    period_d = period_q;
    cnt_d    = cnt_q;
    half_d   = half_q;
    if (load) begin
      period_d = period;
      cnt_d    = ld_setup_len - PW'(1);
      half_d   = HALF_SETUP;
    end else if (run) begin
      if (cnt_q == '0) begin
        if (half_q == HALF_SETUP) begin
          half_d = HALF_HOLD;
          cnt_d  = cur_hold_len - PW'(1);
        end
      end else begin
        cnt_d = cnt_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PW'(2);
      cnt_q    <= '0;
      half_q   <= HALF_SETUP;
    end else begin
      if (load) begin
        period_q <= period_d;
      end
      if (load || run) begin
        cnt_q  <= cnt_d;
        half_q <= half_d;
      end
    end
  end

  assign in_hold     = (half_q == HALF_HOLD);
  assign first_setup = run && (half_q == HALF_SETUP) && (cnt_q == cur_setup_len - PW'(1));
  assign first_hold  = run && (half_q == HALF_HOLD) && (cnt_q == cur_hold_len - PW'(1));
  assign bit_end     = run && (half_q == HALF_HOLD) && (cnt_q == '0);

endmodule

// File: rtl/spi_clkgen_bitcnt.sv
module spi_clkgen_bitcnt #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [LW-1:0] wr_len,
  input  logic [LW-1:0] rd_len,
  output logic          in_read,
  output logic          last_bit,
  output logic          next_is_write
);

  logic [LW-1:0] wr_left_q, wr_left_d;
  logic [LW-1:0] rd_left_q, rd_left_d;

  always_comb begin
    wr_left_d = wr_left_q;
    rd_left_d = rd_left_q;
    if (load) begin
      wr_left_d = wr_len;
      rd_left_d = rd_len;
    end else if (dec) begin
      if (wr_left_q != '0) begin
        wr_left_d = wr_left_q - LW'(1);
      end else if (rd_left_q != '0) begin
        rd_left_d = rd_left_q - LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_left_q <= '0;
      rd_left_q <= '0;
    end else if (load || dec) begin
      wr_left_q <= wr_left_d;
      rd_left_q <= rd_left_d;
    end
  end

  assign in_read       = (wr_left_q == '0);
  assign last_bit      = ((wr_left_q == LW'(1)) && (rd_left_q == '0)) ||
                         ((wr_left_q == '0) && (rd_left_q == LW'(1)));
  assign next_is_write = (wr_left_q > LW'(1));

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] wdiv_m2,
  input  logic [DIV_W-1:0] rdiv_m2,
  input  logic             clk_pol,
  input  logic             clk_pha,
  input  logic [LEN_W-1:0] wr_bits,
  input  logic [LEN_W-1:0] rd_bits,
  input  logic             start,
  output logic             sclk,
  output logic             launch,
  output logic             sample,
  output logic             phase_rd,
  output logic             done,
  output logic             busy
);

  localparam int PW = DIV_W + 1;

  logic rst_n_int;

  spi_clkgen_rstsync #(.STAGES(2)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Captured settings
  logic [DIV_W-1:0] wdiv_q, rdiv_q;
  logic             lead_q;
  logic             active_q, active_d;
  logic             zdone_q, zdone_d;

  // Sub-block wiring
  logic          hc_load, hc_hold, hc_first_setup, hc_first_hold, hc_bit_end;
  logic [PW-1:0] hc_period;
  logic          bc_load, bc_dec, bc_in_read, bc_last, bc_next_wr;

  logic          xfer_end, accept, zero_len, begin_x, next_bit;
  logic [PW-1:0] new_wr_period, new_rd_period, cur_wr_period, cur_rd_period;

  always_comb begin
    new_wr_period = {1'b0, wdiv_m2} + PW'(2);
    new_rd_period = {1'b0, rdiv_m2} + PW'(2);
    cur_wr_period = {1'b0, wdiv_q} + PW'(2);
    cur_rd_period = {1'b0, rdiv_q} + PW'(2);

    xfer_end = active_q && hc_bit_end && bc_last;
    accept   = start && (!active_q || xfer_end);
    zero_len = (wr_bits == '0) && (rd_bits == '0);
    begin_x  = accept && !zero_len;
    next_bit = active_q && hc_bit_end && !bc_last;

    hc_load = begin_x || next_bit;
    if (begin_x) begin
      hc_period = (wr_bits != '0) ? new_wr_period : new_rd_period;
    end else begin
      hc_period = bc_next_wr ? cur_wr_period : cur_rd_period;
    end

    bc_load = begin_x;
    bc_dec  = active_q && hc_bit_end && !begin_x;

    active_d = active_q;
    if (accept) begin
      active_d = !zero_len;
    end else if (xfer_end) begin
      active_d = 1'b0;
    end
    zdone_d = accept && zero_len;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      active_q <= 1'b0;
      zdone_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      zdone_q  <= zdone_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      wdiv_q <= '0;
      rdiv_q <= '0;
      lead_q <= 1'b0;
    end else if (begin_x) begin
      wdiv_q <= wdiv_m2;
      rdiv_q <= rdiv_m2;
      lead_q <= clk_pol ^ clk_pha;
    end
  end

  spi_clkgen_halfcnt #(.PW(PW)) u_halfcnt (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .load        (hc_load),
    .run         (active_q),
    .period      (hc_period),
    .in_hold     (hc_hold),
    .first_setup (hc_first_setup),
    .first_hold  (hc_first_hold),
    .bit_end     (hc_bit_end)
  );

  spi_clkgen_bitcnt #(.LW(LEN_W)) u_bitcnt (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .load          (bc_load),
    .dec           (bc_dec),
    .wr_len        (wr_bits),
    .rd_len        (rd_bits),
    .in_read       (bc_in_read),
    .last_bit      (bc_last),
    .next_is_write (bc_next_wr)
  );

  assign sclk     = active_q ? (hc_hold ? ~lead_q : lead_q) : clk_pol;
  assign launch   = hc_first_setup;
  assign sample   = hc_first_hold;
  assign phase_rd = active_q && bc_in_read;
  assign done     = xfer_end || zdone_q;
  assign busy     = active_q;

endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic clk_pol,
  input logic sclk,
  input logic launch,
  input logic sample,
  input logic phase_rd,
  input logic done,
  input logic busy
);

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == clk_pol));

  assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sample));

  assert_sample_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (sclk != $past(sclk)));

  assert_first_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> launch);

  assert_stop_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy && !start) |=> !busy);

  assert_no_early_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_read_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_rd && !start) |=> (phase_rd || !busy));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!launch && !sample && !phase_rd));

endmodule

bind spi_clkgen spi_clkgen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .clk_pol  (clk_pol),
  .sclk     (sclk),
  .launch   (launch),
  .sample   (sample),
  .phase_rd (phase_rd),
  .done     (done),
  .busy     (busy)
);

// File: tb/spi_clkgen_tb.sv
`timescale 1ns/1ps
module spi_clkgen_tb;

  localparam int DIV_W = 8;
  localparam int LEN_W = 6;

  logic             clk;
  logic             rst_n;
  logic [DIV_W-1:0] wdiv_m2, rdiv_m2;
  logic             clk_pol, clk_pha;
  logic [LEN_W-1:0] wr_bits, rd_bits;
  logic             start;
  logic             sclk, launch, sample, phase_rd, done, busy;

  int checks;
  int errors;
  int n_wd, n_rd, n_wb, n_rb;
  bit n_pol, n_pha;

  spi_clkgen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdiv_m2  (wdiv_m2),
    .rdiv_m2  (rdiv_m2),
    .clk_pol  (clk_pol),
    .clk_pha  (clk_pha),
    .wr_bits  (wr_bits),
    .rd_bits  (rd_bits),
    .start    (start),
    .sclk     (sclk),
    .launch   (launch),
    .sample   (sample),
    .phase_rd (phase_rd),
    .done     (done),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_cfg(input int wd, input int rd, input int wb, input int rb,
                           input bit pol, input bit pha);
    wdiv_m2 = DIV_W'(wd);
    rdiv_m2 = DIV_W'(rd);
    wr_bits = LEN_W'(wb);
    rd_bits = LEN_W'(rb);
    clk_pol = pol;
    clk_pha = pha;
  endtask

  task automatic begin_xfer(input int wd, input int rd, input int wb, input int rb,
                            input bit pol, input bit pha);
    drive_cfg(wd, rd, wb, rb, pol, pha);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Entered at the negedge of the first cycle after the start was taken.
  task automatic xfer(input int wd, input int rd, input int wb, input int rb,
                      input bit pol, input bit pha, input bit scramble,
                      input bit chain, input string tag);
    int total;
    total = wb + rb;
    for (int b = 0; b < total; b++) begin
      int d;
      int s;
      d = (b < wb) ? wd + 2 : rd + 2;
      s = (d + 1) / 2;
      for (int c = 0; c < d; c++) begin
        bit lead;
        bit lst;
        bit exp_sclk;
        lead = pol ^ pha;
        lst  = (b == total - 1) && (c == d - 1);
        exp_sclk = (c < s) ? lead : ~lead;
        chk(sclk == exp_sclk, {"R5 R2 ", tag}, "sclk", int'(sclk), int'(exp_sclk));
        chk(launch == (c == 0), {"R6 R1 ", tag}, "launch", int'(launch), int'(c == 0));
        chk(sample == (c == s), {"R6 R2 ", tag}, "sample", int'(sample), int'(c == s));
        chk(phase_rd == (b >= wb), {"R3 ", tag}, "phase_rd", int'(phase_rd), int'(b >= wb));
        chk(done == lst, {"R7 ", tag}, "done", int'(done), int'(lst));
        chk(busy == 1'b1, {"R1 ", tag}, "busy", int'(busy), 1);
        if (lst) begin
          if (chain) begin
            drive_cfg(n_wd, n_rd, n_wb, n_rb, n_pol, n_pha);
            start = 1'b1;
          end else begin
            start = 1'b0;
          end
        end else if (scramble) begin
          drive_cfg($urandom % 6, $urandom % 6, $urandom % 8, $urandom % 8,
                    1'($urandom), 1'($urandom));
          start = (($urandom % 3) == 0);
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic idle_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(busy == 1'b0, tag, "busy", int'(busy), 0);
      chk(sclk == clk_pol, {"R4 ", tag}, "idle sclk", int'(sclk), int'(clk_pol));
      chk(!launch && !sample, tag, "strobes", int'({launch, sample}), 0);
      chk(done == 1'b0, tag, "done", int'(done), 0);
      clk_pol = ~clk_pol;
      #0.1;
      chk(sclk == clk_pol, "R4", "idle sclk follows", int'(sclk), int'(clk_pol));
      @(negedge clk);
    end
  endtask

  initial begin
    int c_wd, c_rd, c_wb, c_rb;
    bit c_pol, c_pha;
    bit ch;
    checks = 0;
    errors = 0;
    void'($urandom(32'd51723));
    start = 1'b0;
    rst_n = 1'b0;
    drive_cfg(0, 0, 0, 0, 1'b1, 1'b0);
    @(negedge clk);
    chk(!busy && !launch && !sample && !done && !phase_rd, "R11", "outputs in reset",
        int'({busy, launch, sample, done, phase_rd}), 0);
    chk(sclk == clk_pol, "R11", "sclk in reset", int'(sclk), int'(clk_pol));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !launch, "R11", "outputs after reset",
        int'({busy, done, launch}), 0);

    // Even write divider, odd read divider, mode (0,0)
    begin_xfer(0, 1, 3, 2, 1'b0, 1'b0);
    xfer(0, 1, 3, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    idle_check(3, "R7");

    // Odd write period 5, even read period 4, mode (1,1)
    begin_xfer(3, 2, 2, 2, 1'b1, 1'b1);
    xfer(3, 2, 2, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
    idle_check(2, "R7");

    // Remaining modes, read-only and write-only transfers
    begin_xfer(1, 4, 0, 3, 1'b0, 1'b1);
    xfer(1, 4, 0, 3, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    begin_xfer(2, 0, 2, 0, 1'b1, 1'b0);
    xfer(2, 0, 2, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    idle_check(1, "R4");

    // Empty transfer
    drive_cfg(3, 3, 0, 0, 1'b0, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8", "empty done", int'(done), 1);
    chk(!busy && !launch && !sample, "R8", "empty quiet", int'({busy, launch, sample}), 0);
    chk(sclk == clk_pol, "R8", "empty sclk", int'(sclk), int'(clk_pol));
    @(negedge clk);
    chk(done == 1'b0, "R8", "empty done clears", int'(done), 0);
    chk(busy == 1'b0, "R8", "empty busy", int'(busy), 0);

    // Chained transfer taken in the done cycle
    n_wd = 2; n_rd = 0; n_wb = 1; n_rb = 2; n_pol = 1'b0; n_pha = 1'b0;
    begin_xfer(0, 3, 2, 1, 1'b0, 1'b0);
    xfer(0, 3, 2, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    start = 1'b0;
    xfer(2, 0, 1, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    idle_check(2, "R9");

    // Inputs and starts changing mid-transfer
    begin_xfer(3, 1, 3, 3, 1'b1, 1'b0);
    xfer(3, 1, 3, 3, 1'b1, 1'b0, 1'b1, 1'b0, "R12 R10");
    idle_check(2, "R10");

    // Random transfers, some chained, some with scrambled inputs
    c_wd = $urandom % 5; c_rd = $urandom % 5;
    c_wb = $urandom % 6; c_rb = $urandom % 6;
    if (c_wb + c_rb == 0) c_wb = 1;
    c_pol = 1'($urandom); c_pha = 1'($urandom);
    begin_xfer(c_wd, c_rd, c_wb, c_rb, c_pol, c_pha);
    for (int i = 0; i < 40; i++) begin
      n_wd = $urandom % 5; n_rd = $urandom % 5;
      n_wb = $urandom % 6; n_rb = $urandom % 6;
      if (n_wb + n_rb == 0) n_rb = 1;
      n_pol = 1'($urandom); n_pha = 1'($urandom);
      ch = (i < 39) && (($urandom % 2) == 0);
      xfer(c_wd, c_rd, c_wb, c_rb, c_pol, c_pha, (($urandom % 3) == 0), ch,
           ch ? "R9" : "R12");
      if (ch) begin
        start = 1'b0;
      end else begin
        idle_check(1, "R7");
        if (i < 39) begin
          begin_xfer(n_wd, n_rd, n_wb, n_rb, n_pol, n_pha);
        end
      end
      c_wd = n_wd; c_rd = n_rd; c_wb = n_wb; c_rb = n_rb;
      c_pol = n_pol; c_pha = n_pha;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog: actual no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule